// File: doc/BRIEF.md
# Two-Level Interrupt Cause Controller

This block gathers 64 level-sensitive interrupt sources into two 32-bit cause words. Sources 0 to 31 form the low word and sources 32 to 63 form the high word. Four bits of the high word do not come from the high sources. They carry group summaries from a separate general-purpose-pin interrupt unit. Each word has its own enable mask. A single interrupt line to the CPU is raised whenever any enabled cause bit is active.

Software reaches the block through a simple 32-bit register bus. Writes land on the rising clock edge. Reads are combinational from the address. A select-cause register lets the interrupt handler fetch one enabled cause word in a single read. A flag bit in that word tells the handler which of the two words it received.

Top module: `irq_cause_ctrl`

## Requirements
- R1: The low cause register (offset 0x04) shows `src_lo_i` as it was sampled on the previous rising edge. A bit drops as soon as its input drops; nothing is latched.
- R2: The high cause register (offset 0x0C) shows `src_hi_i` sampled on the previous edge, except bits 27:24. Those four bits show `gpp_grp_i[3:0]` instead, and `src_hi_i[27:24]` is ignored.
- R3: The low mask (offset 0x14) and the high mask (offset 0x1C) read back the last value written to them. Both read as zero after reset.
- R4: A write to either cause offset, including a write of zero, changes no register. Cause reads and mask reads after such a write are the same as without it.
- R5: When the low cause ANDed with the low mask is nonzero, select-cause (offset 0x24) returns that masked low word with bit 30 forced to 0.
- R6: Otherwise select-cause returns the high cause ANDed with the high mask, with bit 30 forced to 1. High source 62 therefore cannot be seen through select-cause.
- R7: `irq_o` is 1 exactly when some enabled cause bit is set in either word, and this includes the summary bits 27:24 of the high word. It follows a source change on the same edge that updates the cause registers.
- R8: A read of any offset other than 0x04, 0x0C, 0x14, 0x1C and 0x24 returns zero.
- R9: A source whose mask bit is 0 never raises `irq_o` and never appears in select-cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_lo_i | input | 32 | Level sources 0 to 31 |
| src_hi_i | input | 32 | Level sources 32 to 63 (bits 27:24 unused) |
| gpp_grp_i | input | 4 | Summary levels from the pin interrupt unit |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Two things can happen in the same cycle: a mask write and a change on the source inputs. The bench provokes this by driving a new low-mask value and a new low-source pattern before the same rising edge. It then reads select-cause and samples `irq_o` just after that edge. The expected result uses both new values together, so a stale mask or a stale cause word shows up as a mismatch. A second case does the same with the summary inputs against the high mask.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int SEL_HI_BIT = 30;
  localparam int GPP_LSB    = 24;
  localparam int GPP_W      = 4;

  localparam logic [ADDR_W-1:0] OFF_CAUSE_LO = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CAUSE_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_SELECT   = 8'h24;

  typedef enum logic {
    GRP_LO = 1'b0,
    GRP_HI = 1'b1
  } grp_e;
endpackage

// File: rtl/irq_cause_sampler.sv
module irq_cause_sampler #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_o <= '0;
    else         cause_o <= lvl_i;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int                                   W   = 32,
  parameter logic [irq_cause_pkg::ADDR_W-1:0] OFF = '0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [irq_cause_pkg::ADDR_W-1:0] addr_i,
  input  logic [W-1:0]                      wdata_i,
  output logic [W-1:0]                      mask_o
);
  logic hit;
  assign hit = wr_i && (addr_i == OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mask_o <= '0;
    else if (hit) mask_o <= wdata_i;
  end
endmodule

// File: rtl/irq_sel_cause.sv
module irq_sel_cause
  import irq_cause_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] cause_lo_i,
  input  logic [W-1:0] cause_hi_i,
  input  logic [W-1:0] mask_lo_i,
  input  logic [W-1:0] mask_hi_i,
  output logic [W-1:0] sel_o,
  output logic         any_o
);
  logic [W-1:0] act_lo, act_hi;
  grp_e         grp;

  assign act_lo = cause_lo_i & mask_lo_i;
  assign act_hi = cause_hi_i & mask_hi_i;
  assign grp    = (|act_lo) ? GRP_LO : GRP_HI;

  always_comb begin
    if (grp == GRP_LO) begin
      sel_o             = act_lo;
      sel_o[SEL_HI_BIT] = 1'b0;
    end else begin
      sel_o             = act_hi;
      sel_o[SEL_HI_BIT] = 1'b1;
    end
  end

  assign any_o = (|act_lo) | (|act_hi);
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int SUM_LO = GPP_LSB,
  parameter int SUM_W  = GPP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      src_lo_i,
  input  logic [W-1:0]      src_hi_i,
  input  logic [SUM_W-1:0]  gpp_grp_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  output logic              irq_o
);
  localparam int N_GRP = 2;

  logic [N_GRP-1:0][W-1:0] lvl_in, cause_q;
  logic [W-1:0]            mask_lo_q, mask_hi_q, sel_word;

  // summary bits of the pin unit displace the matching high-source bits
  always_comb begin
    lvl_in[0]                   = src_lo_i;
    lvl_in[1]                   = src_hi_i;
    lvl_in[1][SUM_LO +: SUM_W]  = gpp_grp_i;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    irq_cause_sampler #(.W(W)) u_smp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (lvl_in[g]),
      .cause_o (cause_q[g])
    );
  end

  irq_mask_reg #(.W(W), .OFF(OFF_MASK_LO)) u_mask_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .mask_o(mask_lo_q)
  );

  irq_mask_reg #(.W(W), .OFF(OFF_MASK_HI)) u_mask_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .mask_o(mask_hi_q)
  );

  irq_sel_cause #(.W(W)) u_sel (
    .cause_lo_i (cause_q[0]),
    .cause_hi_i (cause_q[1]),
    .mask_lo_i  (mask_lo_q),
    .mask_hi_i  (mask_hi_q),
    .sel_o      (sel_word),
    .any_o      (irq_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      OFF_CAUSE_LO: bus_rdata_o = cause_q[0];
      OFF_CAUSE_HI: bus_rdata_o = cause_q[1];
      OFF_MASK_LO:  bus_rdata_o = mask_lo_q;
      OFF_MASK_HI:  bus_rdata_o = mask_hi_q;
      OFF_SELECT:   bus_rdata_o = sel_word;
      default:      bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk
  import irq_cause_pkg::*;
#(
  parameter int W = DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [W-1:0]      src_lo_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [W-1:0]      bus_wdata_i,
  input logic [W-1:0]      bus_rdata_o,
  input logic              irq_o,
  input logic [W-1:0]      cause_lo,
  input logic [W-1:0]      cause_hi,
  input logic [W-1:0]      mask_lo,
  input logic [W-1:0]      mask_hi
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  assert_low_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> cause_lo == $past(src_lo_i));

  assert_mask_lo_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFF_MASK_LO) |=> mask_lo == $past(bus_wdata_i));

  assert_mask_hi_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == OFF_MASK_HI) |=> mask_hi == $past(bus_wdata_i));

  assert_cause_write_inert_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && (bus_addr_i == OFF_CAUSE_LO || bus_addr_i == OFF_CAUSE_HI))
      |=> ($stable(mask_lo) && $stable(mask_hi)));

  assert_sel_low_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_SELECT && (cause_lo & mask_lo) != '0) |-> !bus_rdata_o[SEL_HI_BIT]);

  assert_sel_high_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_SELECT && (cause_lo & mask_lo) == '0) |-> bus_rdata_o[SEL_HI_BIT]);

  assert_no_enabled_no_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_lo == '0 && mask_hi == '0) |-> !irq_o);

  assert_enabled_raises_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_hi & mask_hi) != '0) |-> irq_o);
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_lo_i    (src_lo_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .cause_lo    (cause_q[0]),
  .cause_hi    (cause_q[1]),
  .mask_lo     (mask_lo_q),
  .mask_hi     (mask_hi_q)
);

// File: tb/irq_cause_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cause_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lo = '0, src_hi = '0, wdata = '0;
  logic [3:0]  gpp = '0;
  logic [7:0]  wr_addr = '0, rd_addr = '0, bus_addr;
  logic        bus_wr = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] data;
    logic        irq;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;
  assign bus_addr = bus_wr ? wr_addr : rd_addr;

  irq_cause_ctrl u_irq_cause_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_lo_i(src_lo), .src_hi_i(src_hi),
    .gpp_grp_i(gpp), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // monitor: one expected item per cycle, read just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        rd_addr = it.addr;
        #1;
        total++;
        if (rdata !== it.data || irq !== it.irq) begin
          bad++;
          $display("FAIL %s addr=%h data=%h irq=%b expected data=%h irq=%b",
                   it.tag, it.addr, rdata, irq, it.data, it.irq);
        end
      end
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] d,
                           input logic i, input string tag);
    item_t it;
    it.addr = a; it.data = d; it.irq = i; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic set_src(input logic [31:0] lo, input logic [31:0] hi, input logic [3:0] g);
    @(negedge clk);
    src_lo = lo; src_hi = hi; gpp = g;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a; wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset values
    expect_rd(8'h14, 32'h0, 1'b0, "R3 mask lo reset");
    expect_rd(8'h1C, 32'h0, 1'b0, "R3 mask hi reset");
    // R1 level follow, R9 masked off
    set_src(32'hA5A5_0001, 32'h0, 4'h0);
    expect_rd(8'h04, 32'hA5A5_0001, 1'b0, "R1 low cause / R9 masked");
    set_src(32'h0, 32'h0, 4'h0);
    expect_rd(8'h04, 32'h0, 1'b0, "R1 low cause drops");
    // R2 summary replaces bits 27:24
    set_src(32'h0, 32'hFFFF_FFFF, 4'h5);
    expect_rd(8'h0C, 32'hF5FF_FFFF, 1'b0, "R2 high cause with summary");
    // R4 cause writes inert
    wr_reg(8'h0C, 32'h0);
    expect_rd(8'h0C, 32'hF5FF_FFFF, 1'b0, "R4 high cause after write");
    set_src(32'h12, 32'hFFFF_FFFF, 4'h5);
    wr_reg(8'h04, 32'hFFFF_FFFF);
    expect_rd(8'h04, 32'h12, 1'b0, "R4 low cause after write");
    expect_rd(8'h14, 32'h0, 1'b0, "R4 mask lo untouched");
    // R3 mask readback
    wr_reg(8'h14, 32'h0000_00F0);
    expect_rd(8'h14, 32'h0000_00F0, 1'b1, "R3 mask lo readback");
    wr_reg(8'h1C, 32'h4000_0001);
    expect_rd(8'h1C, 32'h4000_0001, 1'b1, "R3 mask hi readback");
    // R5 low chosen, R6 fallback high
    expect_rd(8'h24, 32'h0000_0010, 1'b1, "R5 select low");
    set_src(32'h02, 32'hFFFF_FFFF, 4'h5);
    expect_rd(8'h24, 32'h4000_0001, 1'b1, "R6 select high");
    // R6 source 62 hidden
    wr_reg(8'h1C, 32'h4000_0000);
    expect_rd(8'h24, 32'h4000_0000, 1'b1, "R6 src62 set");
    set_src(32'h02, 32'h0, 4'h0);
    expect_rd(8'h24, 32'h4000_0000, 1'b0, "R6 src62 clear");
    // R8 unmapped
    expect_rd(8'h08, 32'h0, 1'b0, "R8 offset 08");
    expect_rd(8'h30, 32'h0, 1'b0, "R8 offset 30");
    // same cycle: mask write with source change
    @(negedge clk);
    src_lo = 32'h1; wr_addr = 8'h14; wdata = 32'h1; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    expect_rd(8'h24, 32'h0000_0001, 1'b1, "R5 same-cycle mask and source");
    // R7 summary bit drives irq
    wr_reg(8'h14, 32'h0);
    @(negedge clk);
    src_lo = 32'h0; gpp = 4'h8; wr_addr = 8'h1C; wdata = 32'h0800_0000; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    expect_rd(8'h24, 32'h4800_0000, 1'b1, "R7 summary irq");
    set_src(32'h0, 32'h0, 4'h0);
    expect_rd(8'h24, 32'h4000_0000, 1'b0, "R7 summary drops");
    // R5 low bit 30 cleared in select
    wr_reg(8'h14, 32'hFFFF_FFFF);
    set_src(32'h4000_0000, 32'h0, 4'h0);
    expect_rd(8'h24, 32'h0, 1'b1, "R5 low bit30 cleared");
    // R9 all disabled
    wr_reg(8'h14, 32'h0);
    wr_reg(8'h1C, 32'h0);
    set_src(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'hF);
    expect_rd(8'h24, 32'h4000_0000, 1'b0, "R9 nothing enabled");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule